// File: doc/BRIEF.md
# Clause 45 Management Mailbox Bridge

This block sits behind a two-wire target front end on a pluggable module and gives the host indirect access to the module's internal PHY. The front end presents each host access as a byte-wide register read or write; the bridge keeps a small set of mailbox bytes and, on command, runs a Clause 45 MDIO transaction as the bus master. The host loads the device address, the 16-bit register address and (for a write) the 16-bit value, then writes a command byte. Completion shows as a done code in that same command byte, which the host polls; a whole operation is slow compared with the host's accesses.

The mailbox only responds once the host has selected page 0x03 and loaded an all-ones 32-bit unlock key. The control state machine has six states: `S_IDLE` (waiting), `S_ADDR_GO` (launch the address frame), `S_ADDR_WAIT` (address frame on the wire), `S_DATA_GO` (launch the write or read frame), `S_DATA_WAIT` (second frame on the wire) and `S_DONE` (post the done code and any read result). Transitions: `S_IDLE`→`S_ADDR_GO` on an accepted command write; each `GO` state moves to its `WAIT` state after one cycle; `S_ADDR_WAIT`→`S_DATA_GO` and `S_DATA_WAIT`→`S_DONE` when the frame engine reports its last bit; `S_DONE`→`S_IDLE` after one cycle.

Top module: `c45_mailbox_bridge`

## Requirements
- R1: After reset every mailbox, key and page byte reads 0x00, MDC is low and the MDIO output enable is low; both stay low whenever no operation runs.
- R2: Key bytes 0x7B (most significant) to 0x7E and the page byte 0x7F are writable and readable at all times; the window is open only when the page is 0x03 and the key is 0xFFFFFFFF.
- R3: While the window is closed, writes to 0x80–0x85 are ignored, reads of 0x80–0x85 return 0x00, and no MDIO frame is started.
- R4: Byte 0x81 holds a 5-bit device address (bits 7:5 read as 0); 0x82/0x83 hold the register address and 0x84/0x85 the data value, high byte at the lower address.
- R5: Writing 0x01 to 0x80 sends an address frame (op 00, data = register address) followed by a write frame (op 01, data = value).
- R6: Writing 0x02 to 0x80 sends an address frame followed by a read frame (op 11); the 16 bits read land in 0x84/0x85 no later than the command byte turns to 0x04.
- R7: Every frame has 32 preamble ones, start bits 00, the fixed PHY port address parameter, the device address, turnaround 10 on driven frames; on a read frame the output enable is low for the final 18 bit times (turnaround plus data).
- R8: While an operation runs, 0x80 reads back the requested code and writes to 0x80–0x85 are ignored; on completion 0x80 reads 0x04.
- R9: A command value other than 0x01 or 0x02 is ignored: 0x80 keeps its value and no frame starts.
- R10: During a frame MDC has a period of MDC_DIV clocks, and MDIO output changes only while MDC is low.
- R11: Read data updates on the clock after a read strobe and holds its value when no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data byte |
| reg_rd | input | 1 | Read strobe, one cycle per byte |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| mdc | output | 1 | MDIO management clock |
| mdio_o | output | 1 | MDIO data driven by the bridge |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data received from the PHY |

## Verification
A state machine stuck outside `S_IDLE` shows within one poll as a command byte that never reaches 0x04, and a stray launch shows as MDC toggling while the reference model expects a quiet bus, caught on the very next clock. A wrong bit counter in the frame engine appears as misplaced fields or a turnaround window that is not 18 bits long in the frame the bench's PHY model decodes. A wrong lock or busy flag shows as mailbox bytes that change or read back nonzero when the model holds them fixed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_GO,
        S_ADDR_WAIT,
        S_DATA_GO,
        S_DATA_WAIT,
        S_DONE
    } mbx_state_t;

    localparam logic [7:0] CODE_WRITE = 8'h01;
    localparam logic [7:0] CODE_READ  = 8'h02;
    localparam logic [7:0] CODE_DONE  = 8'h04;

    localparam logic [7:0] A_KEY3  = 8'h7B;
    localparam logic [7:0] A_KEY2  = 8'h7C;
    localparam logic [7:0] A_KEY1  = 8'h7D;
    localparam logic [7:0] A_KEY0  = 8'h7E;
    localparam logic [7:0] A_PAGE  = 8'h7F;
    localparam logic [7:0] A_CMD   = 8'h80;
    localparam logic [7:0] A_DEV   = 8'h81;
    localparam logic [7:0] A_REGHI = 8'h82;
    localparam logic [7:0] A_REGLO = 8'h83;
    localparam logic [7:0] A_VALHI = 8'h84;
    localparam logic [7:0] A_VALLO = 8'h85;

    localparam logic [7:0]  OPEN_PAGE = 8'h03;
    localparam logic [31:0] OPEN_KEY  = 32'hFFFF_FFFF;

endpackage

// File: rtl/mbx_bit_timer.sv
module mbx_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign rise = run && (cnt_q == CW'(HALF - 1));
    assign fall = run && (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= fall ? '0 : cnt_q + 1'b1;
            if (rise)
                mdc <= 1'b1;
            else if (fall)
                mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_frame_shifter.sv
module mbx_frame_shifter #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               is_read,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               run,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [15:0]        rdata,
    output logic               done
);
    localparam int IW     = $clog2(FRAME_W);
    localparam int REL_AT = FRAME_W - 18;
    localparam int CAP_AT = FRAME_W - 16;

    logic [FRAME_W-1:0] sh_q;
    logic [IW-1:0]      idx_q;
    logic               rd_q;

    assign mdio_o  = sh_q[FRAME_W-1];
    assign mdio_oe = run && !(rd_q && (idx_q >= IW'(REL_AT)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            rd_q  <= 1'b0;
            run   <= 1'b0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh_q  <= frame;
                idx_q <= '0;
                rd_q  <= is_read;
                run   <= 1'b1;
            end else if (run) begin
                if (rise && rd_q && (idx_q >= IW'(CAP_AT)))
                    rdata <= {rdata[14:0], mdio_i};
                if (fall) begin
                    if (idx_q == IW'(FRAME_W - 1)) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sh_q  <= sh_q << 1;
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/c45_mailbox_bridge.sv
module c45_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int         MDC_DIV   = 4,
    parameter logic [4:0] PORT_ADDR = 5'd3,
    parameter int         PRE_LEN   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i
);
    localparam int FRAME_W = PRE_LEN + 32;
    localparam logic [PRE_LEN-1:0] PREAMBLE = '1;

    mbx_state_t state_q, state_d;

    logic [31:0] key_q;
    logic [7:0]  page_q, cmd_q;
    logic [4:0]  dev_q;
    logic [15:0] reg_q, val_q;

    logic unlocked, win_hit, win_wr, launch, is_rd_op;
    logic fr_start, fr_read, fr_run, fr_done, t_rise, t_fall;
    logic [FRAME_W-1:0] fr_word;
    logic [15:0] fr_rdata;

    assign unlocked = (page_q == OPEN_PAGE) && (key_q == OPEN_KEY);
    assign win_hit  = (reg_addr >= A_CMD) && (reg_addr <= A_VALLO);
    assign win_wr   = reg_wr && win_hit && unlocked && (state_q == S_IDLE);
    assign launch   = win_wr && (reg_addr == A_CMD) &&
                      ((reg_wdata == CODE_WRITE) || (reg_wdata == CODE_READ));
    assign is_rd_op = (cmd_q == CODE_READ);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (launch) state_d = S_ADDR_GO;
            S_ADDR_GO:   state_d = S_ADDR_WAIT;
            S_ADDR_WAIT: if (fr_done) state_d = S_DATA_GO;
            S_DATA_GO:   state_d = S_DATA_WAIT;
            S_DATA_WAIT: if (fr_done) state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs of the state machine towards the frame engine
    always_comb begin
        fr_start = 1'b0;
        fr_read  = 1'b0;
        fr_word  = {PREAMBLE, 2'b00, 2'b00, PORT_ADDR, dev_q, 2'b10, reg_q};
        unique case (state_q)
            S_ADDR_GO: fr_start = 1'b1;
            S_DATA_GO: begin
                fr_start = 1'b1;
                fr_read  = is_rd_op;
                if (is_rd_op)
                    fr_word = {PREAMBLE, 2'b00, 2'b11, PORT_ADDR, dev_q, 2'b11, 16'hFFFF};
                else
                    fr_word = {PREAMBLE, 2'b00, 2'b01, PORT_ADDR, dev_q, 2'b10, val_q};
            end
            default: ;
        endcase
    end

    // mailbox, key and page bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            page_q <= '0;
            cmd_q  <= '0;
            dev_q  <= '0;
            reg_q  <= '0;
            val_q  <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_KEY3:  key_q[31:24] <= reg_wdata;
                    A_KEY2:  key_q[23:16] <= reg_wdata;
                    A_KEY1:  key_q[15:8]  <= reg_wdata;
                    A_KEY0:  key_q[7:0]   <= reg_wdata;
                    A_PAGE:  page_q       <= reg_wdata;
                    default: ;
                endcase
            end
            if (win_wr) begin
                unique case (reg_addr)
                    A_CMD:   if (launch) cmd_q <= reg_wdata;
                    A_DEV:   dev_q        <= reg_wdata[4:0];
                    A_REGHI: reg_q[15:8]  <= reg_wdata;
                    A_REGLO: reg_q[7:0]   <= reg_wdata;
                    A_VALHI: val_q[15:8]  <= reg_wdata;
                    A_VALLO: val_q[7:0]   <= reg_wdata;
                    default: ;
                endcase
            end
            if (state_q == S_DONE) begin
                cmd_q <= CODE_DONE;
                if (is_rd_op)
                    val_q <= fr_rdata;
            end
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= 8'h00;
            unique case (reg_addr)
                A_KEY3:  reg_rdata <= key_q[31:24];
                A_KEY2:  reg_rdata <= key_q[23:16];
                A_KEY1:  reg_rdata <= key_q[15:8];
                A_KEY0:  reg_rdata <= key_q[7:0];
                A_PAGE:  reg_rdata <= page_q;
                A_CMD:   if (unlocked) reg_rdata <= cmd_q;
                A_DEV:   if (unlocked) reg_rdata <= {3'b000, dev_q};
                A_REGHI: if (unlocked) reg_rdata <= reg_q[15:8];
                A_REGLO: if (unlocked) reg_rdata <= reg_q[7:0];
                A_VALHI: if (unlocked) reg_rdata <= val_q[15:8];
                A_VALLO: if (unlocked) reg_rdata <= val_q[7:0];
                default: ;
            endcase
        end
    end

    mbx_bit_timer #(.DIV(MDC_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (fr_run),
        .mdc  (mdc),
        .rise (t_rise),
        .fall (t_fall)
    );

    mbx_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fr_start),
        .frame  (fr_word),
        .is_read(fr_read),
        .rise   (t_rise),
        .fall   (t_fall),
        .mdio_i (mdio_i),
        .run    (fr_run),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .rdata  (fr_rdata),
        .done   (fr_done)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input mbx_state_t state_q,
    input logic [7:0] cmd_q,
    input logic       unlocked,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       reg_rd,
    input logic [7:0] reg_rdata
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (!mdc && !mdio_oe));

    p_closed_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !unlocked) |=> (state_q == S_IDLE));

    p_done_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> (cmd_q == CODE_DONE));

    p_cmd_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR_GO || state_q == S_ADDR_WAIT ||
         state_q == S_DATA_GO || state_q == S_DATA_WAIT) |=> $stable(cmd_q));

    p_mdo_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

bind c45_mailbox_bridge mbx_checker u_mbx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .cmd_q    (cmd_q),
    .unlocked (unlocked),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata)
);

// File: tb/c45_mailbox_bridge_bench.sv
module c45_mailbox_bridge_bench;
    localparam int         DIV  = 4;
    localparam logic [4:0] PRTA = 5'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       mdc, mdio_o, mdio_oe;
    logic       mdio_i = 1'b1;

    c45_mailbox_bridge #(.MDC_DIV(DIV), .PORT_ADDR(PRTA), .PRE_LEN(32)) u_c45_mailbox_bridge (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model of the mailbox
    logic [31:0] m_key = '0;
    logic [7:0]  m_page = '0, m_cmd = '0;
    logic [4:0]  m_dev = '0;
    logic [15:0] m_reg = '0, m_val = '0;
    bit          m_busy = 1'b0;

    function automatic bit m_open();
        return (m_page == 8'h03) && (m_key == 32'hFFFF_FFFF);
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        case (a)
            8'h7B: return m_key[31:24];
            8'h7C: return m_key[23:16];
            8'h7D: return m_key[15:8];
            8'h7E: return m_key[7:0];
            8'h7F: return m_page;
            8'h80: return m_open() ? m_cmd : 8'h00;
            8'h81: return m_open() ? {3'b000, m_dev} : 8'h00;
            8'h82: return m_open() ? m_reg[15:8] : 8'h00;
            8'h83: return m_open() ? m_reg[7:0] : 8'h00;
            8'h84: return m_open() ? m_val[15:8] : 8'h00;
            8'h85: return m_open() ? m_val[7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(logic [7:0] a, logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        case (a)
            8'h7B: m_key[31:24] = v;
            8'h7C: m_key[23:16] = v;
            8'h7D: m_key[15:8]  = v;
            8'h7E: m_key[7:0]   = v;
            8'h7F: m_page       = v;
            default:
                if (m_open() && !m_busy) begin
                    case (a)
                        8'h80: if (v == 8'h01 || v == 8'h02) begin m_cmd = v; m_busy = 1'b1; end
                        8'h81: m_dev = v[4:0];
                        8'h82: m_reg[15:8] = v;
                        8'h83: m_reg[7:0]  = v;
                        8'h84: m_val[15:8] = v;
                        8'h85: m_val[7:0]  = v;
                        default: ;
                    endcase
                end
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rdchk(logic [7:0] a, string req);
        logic [7:0] v;
        rd(a, v);
        chk(req, $sformatf("byte %0h", a), v, m_read(a));
    endtask

    task automatic poll(string req);
        logic [7:0] v = 8'h00;
        for (int i = 0; i < 400; i++) begin
            rd(8'h80, v);
            if (v == 8'h04) break;
            chk("R8", "command byte while busy", v, m_cmd);
        end
        chk(req, "done code", v, 8'h04);
        m_busy = 1'b0;
        m_cmd  = 8'h04;
    endtask

    // per-clock comparison: bus quiet whenever the model has no operation
    always @(negedge clk) begin
        if (rst_n && !m_busy && !finished) begin
            chk("R1", "idle mdc", mdc, 0);
            chk("R1", "idle oe", mdio_oe, 0);
        end
    end

    always @(posedge clk) cyc++;

    // ---------------- behavioural PHY model on the MDIO pins
    logic [15:0] pmem [int unsigned];
    logic [63:0] fq [$];
    int          oelq [$];
    logic [63:0] fb = '0;
    logic [15:0] cur_addr = '0, rd_val = '0;
    int pcnt = 0, oel = 0, last_rise = 0, bad_iv = 0, rises = 0;
    bit rd_active = 1'b0;

    function automatic logic [15:0] phy_val(logic [4:0] d, logic [15:0] a);
        int unsigned k = {d, a};
        if (pmem.exists(k)) return pmem[k];
        return a ^ {11'h0, d} ^ 16'h5A5A;
    endfunction

    always @(posedge mdc) begin
        logic b;
        b = mdio_oe ? mdio_o : mdio_i;
        if (pcnt != 0 && (cyc - last_rise) != DIV) bad_iv++;
        last_rise = cyc;
        rises++;
        fb = {fb[62:0], b};
        if (!mdio_oe) oel++;
        pcnt++;
        if (pcnt == 46 && fb[11:10] == 2'b11) begin
            rd_val = phy_val(fb[4:0], cur_addr);
            rd_active = 1'b1;
        end
        if (pcnt == 64) begin
            fq.push_back(fb);
            oelq.push_back(oel);
            if (fb[29:28] == 2'b00) cur_addr = fb[15:0];
            if (fb[29:28] == 2'b01) pmem[{fb[22:18], cur_addr}] = fb[15:0];
            oel = 0; pcnt = 0; rd_active = 1'b0; mdio_i = 1'b1;
        end
    end

    always @(negedge mdc) begin
        if (rd_active)
            mdio_i = (pcnt >= 48) ? rd_val[63-pcnt] : ((pcnt == 47) ? 1'b0 : 1'b1);
    end

    task automatic chk_frame(string req, logic [1:0] op, logic [4:0] dev, logic [15:0] data);
        logic [63:0] f;
        int ol;
        chk(req, "frame present", fq.size() > 0, 1);
        if (fq.size() == 0) return;
        f  = fq.pop_front();
        ol = oelq.pop_front();
        chk("R7", "preamble", f[63:32], 32'hFFFF_FFFF);
        chk("R7", "start bits", f[31:30], 2'b00);
        chk(req, "op code", f[29:28], op);
        chk("R7", "port address", f[27:23], PRTA);
        chk("R7", "device", f[22:18], dev);
        if (op != 2'b11) chk("R7", "turnaround", f[17:16], 2'b10);
        chk(req, "frame data", f[15:0], data);
        chk("R7", "released bit times", ol, (op == 2'b11) ? 18 : 0);
    endtask

    // ---------------- watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus
    initial begin
        logic [7:0] v;
        logic [15:0] exp_rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "mdc after reset", mdc, 0);
        chk("R1", "oe after reset", mdio_oe, 0);
        rdchk(8'h80, "R1"); rdchk(8'h7F, "R1"); rdchk(8'h7B, "R1");

        // R3 closed window
        wr(8'h81, 8'h1F); wr(8'h84, 8'hAB); wr(8'h80, 8'h02);
        rdchk(8'h81, "R3"); rdchk(8'h84, "R3"); rdchk(8'h80, "R3");
        repeat (100) @(negedge clk);
        chk("R3", "no frame while closed", fq.size(), 0);

        // R2 key and page, partial key keeps window closed
        wr(8'h7B, 8'hFF); wr(8'h7C, 8'hFF); wr(8'h7D, 8'hFF); wr(8'h7E, 8'h00);
        wr(8'h7F, 8'h03);
        rdchk(8'h7E, "R2"); rdchk(8'h7F, "R2"); rdchk(8'h7B, "R2");
        wr(8'h81, 8'h05);
        rdchk(8'h81, "R2");
        wr(8'h7E, 8'hFF);

        // R4 field layout
        wr(8'h81, 8'hFF);
        rdchk(8'h81, "R4");
        wr(8'h82, 8'h12); wr(8'h83, 8'h34); wr(8'h84, 8'hBE); wr(8'h85, 8'hEF);
        rdchk(8'h82, "R4"); rdchk(8'h83, "R4"); rdchk(8'h84, "R4"); rdchk(8'h85, "R4");

        // R9 unknown command
        wr(8'h80, 8'h07);
        rdchk(8'h80, "R9");
        repeat (50) @(negedge clk);
        chk("R9", "no frame on unknown code", fq.size(), 0);

        // R5 write operation, R8 writes ignored while busy
        wr(8'h80, 8'h01);
        wr(8'h84, 8'h00);
        rdchk(8'h80, "R8");
        poll("R5");
        rdchk(8'h84, "R8");
        chk_frame("R5", 2'b00, 5'h1F, 16'h1234);
        chk_frame("R5", 2'b01, 5'h1F, 16'hBEEF);

        // R6 read back the same register
        wr(8'h84, 8'h00); wr(8'h85, 8'h00);
        wr(8'h80, 8'h02);
        poll("R6");
        m_val = 16'hBEEF;
        rdchk(8'h84, "R6"); rdchk(8'h85, "R6");
        chk_frame("R6", 2'b00, 5'h1F, 16'h1234);
        chk_frame("R6", 2'b11, 5'h1F, 16'hBEEF);

        // R6 read of an untouched register
        wr(8'h81, 8'h02); wr(8'h82, 8'h00); wr(8'h83, 8'h07);
        exp_rd = phy_val(5'h02, 16'h0007);
        wr(8'h80, 8'h02);
        poll("R6");
        m_val = exp_rd;
        rdchk(8'h84, "R6"); rdchk(8'h85, "R6");
        chk_frame("R6", 2'b00, 5'h02, 16'h0007);
        chk_frame("R6", 2'b11, 5'h02, exp_rd);

        // R10 clock period and edge count
        chk("R10", "mdc period violations", bad_iv, 0);
        chk("R10", "mdc rising edges", rises, 6 * 64);

        // R11 read data holds without strobe
        rd(8'h81, v);
        @(negedge clk); reg_addr = 8'h82;
        repeat (5) @(negedge clk);
        chk("R11", "read data held", reg_rdata, v);

        // R3 closing again
        wr(8'h7F, 8'h00);
        wr(8'h84, 8'h11);
        rdchk(8'h84, "R3");
        wr(8'h7F, 8'h03);
        rdchk(8'h84, "R3");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule